// File: doc/BRIEF.md
# Early Direct-Branch Mispredict Detector

This block sits in the decode stage and inspects each bundle of up to `W` instruction slots that arrives from fetch. Each slot carries a valid bit, a thread id, a sequence number, the predictor's taken bit and target, the control, direct and unconditional class flags, and a target address computed upstream. Two faults are detected. The first is an unconditional direct branch whose computed target differs from its predicted target. The second is a slot that was predicted taken but is not a control instruction.

Slots are examined in slot order. The first faulty slot is the offender. The offender and the slots before it go on to rename, and the slots after it do not. In the same cycle the block orders a flush of the pending list and the skid buffer, marks as squashed the younger entries of the offender's thread, and gives the corrected target for the offender's stored prediction. One cycle later a registered redirect record goes to fetch. When the stage was stalled, an unblock pulse goes with that record. Three counters track the branches checked, the target mispredicts and the non-control faults.

Top module: `early_branch_check`

## Requirements
- R1: While `rst_ni` is low, and after it, `rec_vld_o` and `unblock_o` read 0 and all three counters read 0 until the first clock edge that carries an event.
- R2: `cnt_chk_o` increases, on the next edge, by the number of valid slots that have both `is_direct_i` and `is_uncond_i` set and lie at or before the offender. When the bundle has no offender, every such slot is counted.
- R3: A valid slot that is direct and unconditional and has `calc_tgt_i != pred_tgt_i` is a target mispredict. When it is the offender, `cnt_mis_o` increases by 1 on the next edge.
- R4: A valid slot with `pred_taken_i=1` and `is_ctrl_i=0` is a non-control fault. This fault takes precedence over the target check in the same slot. When the slot is the offender, `cnt_ctl_o` increases by 1 on the next edge.
- R5: The lowest-index faulty slot is the offender. In the same cycle, `fwd_o` is set for valid, unsquashed slots up to and including the offender, and is clear for every slot after it.
- R6: In the same cycle, `kill_o[i]` is set for a valid slot i that has the same thread id as the offender and a larger sequence number, compared unsigned. Slots with an equal or smaller number, or from another thread, are not killed. A killed slot is never forwarded.
- R7: The edge after an offense cycle, `rec_vld_o`, `rec_brmis_o`, `rec_predbad_o` and `rec_squash_o` are all 1. At the same time, `rec_seq_o` and `rec_tid_o` hold the offender's values, `rec_pc_o` holds its `calc_tgt_i`, and `rec_taken_o` holds its `is_ctrl_i`. After a cycle without an offense, `rec_vld_o` is 0 on the next edge.
- R8: `flush_o` is 1 in every offense cycle and 0 otherwise. `unblock_o` is 1 together with the record exactly when `stage_blk_i` was 1 in the offense cycle.
- R9: In the offense cycle, `fix_o` is one-hot on the offender and `fix_tgt_o` equals the offender's `calc_tgt_i`. `fix_o` is 0 when there is no offender.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| stage_blk_i | input | 1 | decode is Blocked or Unblocking |
| vld_i | input | W | slot valid |
| tid_i | input | W*TW | slot thread id |
| seq_i | input | W*SW | slot sequence number |
| pred_taken_i | input | W | predicted taken |
| pred_tgt_i | input | W*AW | predicted target |
| is_ctrl_i | input | W | slot is a control instruction |
| is_direct_i | input | W | control with a PC-relative target |
| is_uncond_i | input | W | unconditional control |
| calc_tgt_i | input | W*AW | computed target, or fall-through for non-control |
| fwd_o | output | W | slot goes on to rename |
| kill_o | output | W | mark slot squashed |
| flush_o | output | 1 | clear pending list and skid buffer |
| fix_o | output | W | rewrite stored predicted target of this slot |
| fix_tgt_o | output | AW | corrected target value |
| rec_vld_o | output | 1 | redirect record valid |
| rec_brmis_o | output | 1 | branch mispredict flag |
| rec_predbad_o | output | 1 | prediction incorrect flag |
| rec_squash_o | output | 1 | squash flag |
| rec_seq_o | output | SW | offender sequence number |
| rec_pc_o | output | AW | corrected next PC |
| rec_taken_o | output | 1 | offender is a taken control transfer |
| rec_tid_o | output | TW | offender thread |
| unblock_o | output | 1 | unblock pulse to fetch |
| cnt_chk_o | output | CW | direct unconditional branches checked |
| cnt_mis_o | output | CW | target mispredicts |
| cnt_ctl_o | output | CW | non-control predicted-taken faults |

## Verification
`fwd_o`, `kill_o`, `flush_o`, `fix_o` and `fix_tgt_o` are combinational. The bench samples them 5 ns after it drives a bundle on the falling edge, which is before the next rising edge. The record, `unblock_o` and the counters come from one register stage. They are sampled 5 ns after the rising edge that follows the bundle. The bench then drives an idle bundle and checks, one edge later, that the record has dropped. The sequence numbers in each scenario are chosen so that only an unsigned, thread-matched compare gives the expected kill mask.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {
    OFF_NONE    = 2'd0,
    OFF_NOTCTRL = 2'd1,
    OFF_TARGET  = 2'd2
  } offense_e;
endpackage

// File: rtl/ebc_slot_check.sv
module ebc_slot_check import ebc_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          vld_i,
  input  logic          pred_taken_i,
  input  logic          is_ctrl_i,
  input  logic          is_direct_i,
  input  logic          is_uncond_i,
  input  logic [AW-1:0] pred_tgt_i,
  input  logic [AW-1:0] calc_tgt_i,
  output logic          chk_o,
  output offense_e      kind_o
);
  assign chk_o = vld_i & is_direct_i & is_uncond_i;

  // non-control fault checked first
  always_comb begin
    if (vld_i && pred_taken_i && !is_ctrl_i) kind_o = OFF_NOTCTRL;
    else if (chk_o && calc_tgt_i != pred_tgt_i) kind_o = OFF_TARGET;
    else kind_o = OFF_NONE;
  end
endmodule

// File: rtl/ebc_scan.sv
module ebc_scan #(
  parameter int W = 4
) (
  input  logic [W-1:0] off_i,
  output logic [W-1:0] first_o,
  output logic [W-1:0] upto_o,
  output logic         any_o
);
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < W; i++) begin
      upto_o[i]  = !seen;
      first_o[i] = off_i[i] && !seen;
      seen       = seen | off_i[i];
    end
    any_o = seen;
  end
endmodule

// File: rtl/ebc_kill.sv
module ebc_kill #(
  parameter int W  = 4,
  parameter int SW = 16,
  parameter int TW = 1
) (
  input  logic [W-1:0]    vld_i,
  input  logic [W*TW-1:0] tid_i,
  input  logic [W*SW-1:0] seq_i,
  input  logic            any_i,
  input  logic [TW-1:0]   off_tid_i,
  input  logic [SW-1:0]   off_seq_i,
  output logic [W-1:0]    kill_o
);
  for (genvar g = 0; g < W; g++) begin : g_cmp
    // unsigned compare, no wrap handling
    assign kill_o[g] = any_i && vld_i[g] &&
                       (tid_i[g*TW +: TW] == off_tid_i) &&
                       (seq_i[g*SW +: SW] > off_seq_i);
  end
endmodule

// File: rtl/early_branch_check.sv
module early_branch_check import ebc_pkg::*; #(
  parameter int W  = 4,
  parameter int SW = 16,
  parameter int AW = 32,
  parameter int NT = 2,
  parameter int CW = 16,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stage_blk_i,
  input  logic [W-1:0]    vld_i,
  input  logic [W*TW-1:0] tid_i,
  input  logic [W*SW-1:0] seq_i,
  input  logic [W-1:0]    pred_taken_i,
  input  logic [W*AW-1:0] pred_tgt_i,
  input  logic [W-1:0]    is_ctrl_i,
  input  logic [W-1:0]    is_direct_i,
  input  logic [W-1:0]    is_uncond_i,
  input  logic [W*AW-1:0] calc_tgt_i,
  output logic [W-1:0]    fwd_o,
  output logic [W-1:0]    kill_o,
  output logic            flush_o,
  output logic [W-1:0]    fix_o,
  output logic [AW-1:0]   fix_tgt_o,
  output logic            rec_vld_o,
  output logic            rec_brmis_o,
  output logic            rec_predbad_o,
  output logic            rec_squash_o,
  output logic [SW-1:0]   rec_seq_o,
  output logic [AW-1:0]   rec_pc_o,
  output logic            rec_taken_o,
  output logic [TW-1:0]   rec_tid_o,
  output logic            unblock_o,
  output logic [CW-1:0]   cnt_chk_o,
  output logic [CW-1:0]   cnt_mis_o,
  output logic [CW-1:0]   cnt_ctl_o
);
  offense_e      kind [W];
  logic [W-1:0]  chk_v, ctl_v, off_v, first_v, upto_v, kill_v;
  logic          any;
  logic [TW-1:0] o_tid;
  logic [SW-1:0] o_seq;
  logic [AW-1:0] o_pc;
  logic          o_isctl, o_notctl;
  logic [CW-1:0] chk_inc;

  for (genvar g = 0; g < W; g++) begin : g_slot
    ebc_slot_check #(.AW(AW)) u_chk (
      .vld_i       (vld_i[g]),
      .pred_taken_i(pred_taken_i[g]),
      .is_ctrl_i   (is_ctrl_i[g]),
      .is_direct_i (is_direct_i[g]),
      .is_uncond_i (is_uncond_i[g]),
      .pred_tgt_i  (pred_tgt_i[g*AW +: AW]),
      .calc_tgt_i  (calc_tgt_i[g*AW +: AW]),
      .chk_o       (chk_v[g]),
      .kind_o      (kind[g])
    );
    assign ctl_v[g] = (kind[g] == OFF_NOTCTRL);
    assign off_v[g] = (kind[g] != OFF_NONE);
  end

  ebc_scan #(.W(W)) u_scan (
    .off_i  (off_v),
    .first_o(first_v),
    .upto_o (upto_v),
    .any_o  (any)
  );

  always_comb begin
    o_tid = '0; o_seq = '0; o_pc = '0; o_isctl = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (first_v[i]) begin
        o_tid   = tid_i[i*TW +: TW];
        o_seq   = seq_i[i*SW +: SW];
        o_pc    = calc_tgt_i[i*AW +: AW];
        o_isctl = is_ctrl_i[i];
      end
    end
  end
  assign o_notctl = |(first_v & ctl_v);

  ebc_kill #(.W(W), .SW(SW), .TW(TW)) u_kill (
    .vld_i    (vld_i),
    .tid_i    (tid_i),
    .seq_i    (seq_i),
    .any_i    (any),
    .off_tid_i(o_tid),
    .off_seq_i(o_seq),
    .kill_o   (kill_v)
  );

  assign kill_o    = kill_v;
  assign fwd_o     = vld_i & upto_v & ~kill_v;
  assign flush_o   = any;
  assign fix_o     = first_v;
  assign fix_tgt_o = o_pc;

  always_comb begin
    chk_inc = '0;
    for (int i = 0; i < W; i++) chk_inc = chk_inc + CW'(chk_v[i] & upto_v[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_vld_o     <= 1'b0;
      rec_brmis_o   <= 1'b0;
      rec_predbad_o <= 1'b0;
      rec_squash_o  <= 1'b0;
      rec_seq_o     <= '0;
      rec_pc_o      <= '0;
      rec_taken_o   <= 1'b0;
      rec_tid_o     <= '0;
      unblock_o     <= 1'b0;
      cnt_chk_o     <= '0;
      cnt_mis_o     <= '0;
      cnt_ctl_o     <= '0;
    end else begin
      rec_vld_o     <= any;
      rec_brmis_o   <= any;
      rec_predbad_o <= any;
      rec_squash_o  <= any;
      unblock_o     <= any & stage_blk_i;
      if (any) begin
        rec_seq_o   <= o_seq;
        rec_pc_o    <= o_pc;
        rec_taken_o <= o_isctl;
        rec_tid_o   <= o_tid;
      end
      cnt_chk_o <= cnt_chk_o + chk_inc;
      if (any && !o_notctl) cnt_mis_o <= cnt_mis_o + 1'b1;
      if (any && o_notctl)  cnt_ctl_o <= cnt_ctl_o + 1'b1;
    end
  end

  assert_offender_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|first_v) |-> (|(first_v & fwd_o)));
  assert_no_self_kill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_o & kill_o) == '0);
  assert_rec_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> rec_vld_o);
  assert_rec_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_vld_o |-> (rec_brmis_o && rec_predbad_o && rec_squash_o));
  assert_unblock_rec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unblock_o |-> rec_vld_o);
  assert_fix_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fix_o) && (flush_o == (|fix_o)));
endmodule

// File: tb/tb_early_branch_check.sv
`timescale 1ns/1ps
module tb_early_branch_check;
  localparam int W = 4, SW = 16, AW = 32, TW = 1, CW = 16;

  logic clk = 1'b0, rst_ni = 1'b0, stage_blk;
  logic [W-1:0]    vld, pt, ctl, dir, unc;
  logic [W*TW-1:0] tid;
  logic [W*SW-1:0] seq;
  logic [W*AW-1:0] ptgt, ctgt;
  logic [W-1:0]    fwd, kill, fix;
  logic            flush, rec_vld, rec_brmis, rec_predbad, rec_squash, rec_taken, unblock;
  logic [AW-1:0]   fix_tgt, rec_pc;
  logic [SW-1:0]   rec_seq;
  logic [TW-1:0]   rec_tid;
  logic [CW-1:0]   cnt_chk, cnt_mis, cnt_ctl;

  int checks = 0, errors = 0;
  int e_chk = 0, e_mis = 0, e_ctl = 0;

  always #10 clk = ~clk;

  early_branch_check dut (
    .clk_i(clk), .rst_ni(rst_ni), .stage_blk_i(stage_blk),
    .vld_i(vld), .tid_i(tid), .seq_i(seq), .pred_taken_i(pt), .pred_tgt_i(ptgt),
    .is_ctrl_i(ctl), .is_direct_i(dir), .is_uncond_i(unc), .calc_tgt_i(ctgt),
    .fwd_o(fwd), .kill_o(kill), .flush_o(flush), .fix_o(fix), .fix_tgt_o(fix_tgt),
    .rec_vld_o(rec_vld), .rec_brmis_o(rec_brmis), .rec_predbad_o(rec_predbad),
    .rec_squash_o(rec_squash), .rec_seq_o(rec_seq), .rec_pc_o(rec_pc),
    .rec_taken_o(rec_taken), .rec_tid_o(rec_tid), .unblock_o(unblock),
    .cnt_chk_o(cnt_chk), .cnt_mis_o(cnt_mis), .cnt_ctl_o(cnt_ctl));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_bundle();
    vld = '0; pt = '0; ctl = '0; dir = '0; unc = '0;
    tid = '0; seq = '0; ptgt = '0; ctgt = '0; stage_blk = 1'b0;
  endtask

  task automatic set_slot(input int i, input logic t, input logic [SW-1:0] s,
                          input logic p, input logic [AW-1:0] pg, input logic c,
                          input logic d, input logic u, input logic [AW-1:0] cg);
    vld[i] = 1'b1; tid[i*TW +: TW] = t; seq[i*SW +: SW] = s; pt[i] = p;
    ptgt[i*AW +: AW] = pg; ctl[i] = c; dir[i] = d; unc[i] = u; ctgt[i*AW +: AW] = cg;
  endtask

  task automatic check_counts(input string req);
    check(cnt_chk == CW'(e_chk), {req, " chk count"}, cnt_chk, e_chk);
    check(cnt_mis == CW'(e_mis), {req, " mis count"}, cnt_mis, e_mis);
    check(cnt_ctl == CW'(e_ctl), {req, " ctl count"}, cnt_ctl, e_ctl);
  endtask

  // after the record edge: idle bundle, record must drop
  task automatic idle_and_drop(input string req);
    @(negedge clk); clear_bundle();
    @(posedge clk); #5;
    check(rec_vld == 1'b0, {req, " record one cycle"}, rec_vld, 0);
  endtask

  task automatic t_reset();
    #5;
    check(rec_vld == 1'b0, "R1 rec_vld in reset", rec_vld, 0);
    check(unblock == 1'b0, "R1 unblock in reset", unblock, 0);
    check_counts("R1");
  endtask

  task automatic t_clean();
    @(negedge clk); clear_bundle();
    set_slot(0, 0, 16'd1, 1, 32'h100, 1, 1, 1, 32'h100);   // correct direct uncond
    set_slot(1, 0, 16'd2, 1, 32'h300, 1, 0, 0, 32'h999);   // conditional, not checked
    set_slot(2, 0, 16'd3, 0, 32'h0,   0, 0, 0, 32'h0);
    #5;
    check(fwd == 4'b0111, "R5 clean fwd", fwd, 4'b0111);
    check(flush == 1'b0 && fix == '0, "R9 clean no fix/flush", {flush, fix}, 0);
    check(kill == '0, "R6 clean kill", kill, 0);
    e_chk += 1;
    @(posedge clk); #5;
    check(rec_vld == 1'b0, "R7 clean no record", rec_vld, 0);
    check_counts("R2 clean");
  endtask

  task automatic t_target();
    @(negedge clk); clear_bundle();
    set_slot(0, 0, 16'd10, 0, 32'h0,   0, 0, 0, 32'h0);
    set_slot(1, 0, 16'd11, 1, 32'h100, 1, 1, 1, 32'h200);  // offender
    set_slot(2, 1, 16'd12, 0, 32'h0,   0, 0, 0, 32'h0);    // other thread
    set_slot(3, 0, 16'd13, 0, 32'h0,   0, 0, 0, 32'h0);    // younger same thread
    #5;
    check(fwd == 4'b0011, "R5 target fwd", fwd, 4'b0011);
    check(kill == 4'b1000, "R6 target kill", kill, 4'b1000);
    check(fix == 4'b0010, "R9 target fix slot", fix, 4'b0010);
    check(fix_tgt == 32'h200, "R9 target fix value", fix_tgt, 32'h200);
    check(flush == 1'b1, "R8 target flush", flush, 1);
    e_chk += 1; e_mis += 1;
    @(posedge clk); #5;
    check(rec_vld && rec_brmis && rec_predbad && rec_squash, "R7 target flags",
          {rec_vld, rec_brmis, rec_predbad, rec_squash}, 4'hf);
    check(rec_seq == 16'd11 && rec_tid == 1'b0, "R7 target seq", rec_seq, 11);
    check(rec_pc == 32'h200 && rec_taken == 1'b1, "R7 target pc/taken", rec_pc, 32'h200);
    check(unblock == 1'b0, "R8 no unblock when running", unblock, 0);
    check_counts("R3 target");
    idle_and_drop("R7");
  endtask

  task automatic t_notctrl();
    @(negedge clk); clear_bundle();
    stage_blk = 1'b1;
    set_slot(0, 0, 16'd20, 1, 32'h500, 0, 0, 0, 32'h44);   // predicted taken, not control
    set_slot(1, 0, 16'd21, 1, 32'h100, 1, 1, 1, 32'h777);  // also faulty, but later
    set_slot(2, 0, 16'd20, 0, 32'h0,   0, 0, 0, 32'h0);    // equal seq kept
    set_slot(3, 0, 16'd5,  0, 32'h0,   0, 0, 0, 32'h0);    // older kept
    #5;
    check(fwd == 4'b0001, "R5 notctrl fwd", fwd, 4'b0001);
    check(kill == 4'b0010, "R6 notctrl kill equal/older kept", kill, 4'b0010);
    check(fix == 4'b0001 && fix_tgt == 32'h44, "R9 notctrl fix", fix_tgt, 32'h44);
    e_ctl += 1;
    @(posedge clk); #5;
    check(rec_vld && rec_seq == 16'd20, "R7 notctrl seq", rec_seq, 20);
    check(rec_pc == 32'h44 && rec_taken == 1'b0, "R7 notctrl pc/taken", {rec_pc, rec_taken}, {32'h44, 1'b0});
    check(unblock == 1'b1, "R8 unblock when stalled", unblock, 1);
    check_counts("R4 notctrl");
    idle_and_drop("R8");
    check(unblock == 1'b0, "R8 unblock drops", unblock, 0);
  endtask

  task automatic t_order();
    @(negedge clk); clear_bundle();
    set_slot(0, 0, 16'hFFFF, 0, 32'h0,   0, 0, 0, 32'h0);    // larger unsigned, killed
    set_slot(1, 1, 16'h9000, 0, 32'h0,   0, 0, 0, 32'h0);    // other thread
    set_slot(2, 0, 16'h7FFF, 1, 32'h400, 1, 1, 1, 32'h480);  // first offender
    set_slot(3, 0, 16'h8000, 1, 32'h0,   0, 0, 0, 32'h8);    // second offender, killed
    #5;
    check(fwd == 4'b0110, "R5 first offender wins fwd", fwd, 4'b0110);
    check(kill == 4'b1001, "R6 unsigned compare kill", kill, 4'b1001);
    check(fix == 4'b0100 && fix_tgt == 32'h480, "R9 first offender fix", fix, 4'b0100);
    e_chk += 1; e_mis += 1;
    @(posedge clk); #5;
    check(rec_seq == 16'h7FFF && rec_pc == 32'h480, "R7 order record", rec_seq, 16'h7FFF);
    check_counts("R2 order");
    idle_and_drop("R7");
    check_counts("R2 idle");
  endtask

  initial begin
    clear_bundle();
    t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    t_clean();
    t_target();
    t_notctrl();
    t_order();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule